// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits beside an I2C controller core and turns the core's single-cycle event pulses into sticky status flags. A software-visible enable mask selects which of the seven events may raise the interrupt line. A read-only vector register returns the numeric code of the most urgent pending, enabled event. Firmware reads the vector repeatedly and handles each code in turn until it reads zero, so one read gives one cause instead of a bitmap that software must scan.

Flags are cleared in one of two ways, chosen per event. Access-ready, receive-ready and stop-detected are cleared only by writing a one to their own status bit. The other four events (arbitration lost, no-acknowledge, transmit-ready, addressed-as-slave) are cleared by the vector read that reports them. The status register also shows two live levels from the core: receive-shift-full and bus-busy.

The register bus is word-addressed and read data is combinational from the address. Register word offsets are parameters: mask at 0, status at 1, vector at 2 by default. A read takes effect on the vector when the read strobe is high at a clock edge.

Top module: `i2c_ivec_top`

## Requirements
- R1: After reset the mask reads 0, status bits 6..0 read 0, the vector reads 0 and `irq` is low.
- R2: A pulse on event input i sets status bit i at the next clock edge, whether or not mask bit i is set. Bit 0 is arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected and 6 addressed as slave. Mask bit i enables the same event.
- R3: The vector reads i+1 when event i is the only enabled pending event. Codes: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as slave.
- R4: When several enabled events are pending, the vector reports the smallest code.
- R5: The vector reads 0 when no pending event is enabled. Pending but masked events do not appear in it.
- R6: `irq` is high exactly when at least one pending event is enabled by the mask.
- R7: Writing a one to status bit 2, 3 or 5 clears that flag. Zero bits in the write leave flags unchanged.
- R8: Writing ones to status bits 0, 1, 4 or 6 leaves those flags unchanged.
- R9: A strobed read of the vector clears the reported flag when the code is 1, 2, 5 or 7. For codes 3, 4 and 6 the flag stays set.
- R10: Status bit 11 shows `rx_shift_full` and bit 12 shows `bus_busy` live. Writes to the status register do not change them.
- R11: An event pulse arriving in the same cycle as a clear of its flag (status write or vector read) leaves the flag set.
- R12: The mask register stores write data bits 6..0 and reads zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (applies read side effects) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| evt_pulse | input | 7 | One-cycle event pulses from the core, bit i per R2 |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Level interrupt request |

## Verification
A flag can be set and cleared in the same clock cycle. This happens when a core event pulse lands in the cycle of a write-one-to-clear of its status bit, or in the cycle of a strobed vector read that reports it. The bench drives the pulse and the clearing access on the same falling edge and then reads status back. The flag must still be set, since the new event must not be lost. The same two paths are also exercised one at a time, so that each clear is shown to work on its own.

// File: rtl/i2c_ivec_pkg.sv
package i2c_ivec_pkg;
   localparam int unsigned N_EVT    = 7;
   localparam int unsigned CODE_W   = $clog2(N_EVT + 1);
   localparam int unsigned RSF_BIT  = 11;
   localparam int unsigned BUSY_BIT = 12;

   typedef enum logic [CODE_W-1:0] {
      VEC_NONE  = 3'd0,
      VEC_ARB   = 3'd1,
      VEC_NACK  = 3'd2,
      VEC_ACCR  = 3'd3,
      VEC_RXR   = 3'd4,
      VEC_TXR   = 3'd5,
      VEC_STOP  = 3'd6,
      VEC_SLAVE = 3'd7
   } vec_code_e;

   // flags cleared only by writing one to their status bit
   localparam logic [N_EVT-1:0] W1C_SET = 7'b010_1100;
   // flags cleared by the vector read that reports them
   localparam logic [N_EVT-1:0] RDC_SET = ~W1C_SET;
endpackage

// File: rtl/i2c_ivec_flags.sv
module i2c_ivec_flags
   import i2c_ivec_pkg::*;
#(
   parameter int unsigned N = N_EVT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   if (N < 1) begin : g_bad_n
      $error("i2c_ivec_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (set_i[i]) flag_o[i] <= 1'b1;
         else if (clr_i[i]) flag_o[i] <= 1'b0;
      end

      // R11: a new event wins over a simultaneous clear
      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[i] && clr_i[i]) |=> flag_o[i]);
   end
endmodule

// File: rtl/i2c_ivec_prio.sv
module i2c_ivec_prio
   import i2c_ivec_pkg::*;
#(
   parameter int unsigned N  = N_EVT,
   localparam int unsigned CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  req_i,
   output logic [CW-1:0] code_o,
   output logic [N-1:0]  onehot_o
);
   always_comb begin
      code_o   = '0;
      onehot_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            code_o   = CW'(i + 1);
            onehot_o = N'(1) << i;
         end
      end
   end

   // R4: exactly one selected request whenever any is pending
   always_comb begin
      p_onehot_r4: assert ((req_i == '0) ? (onehot_o == '0) : ($countones(onehot_o) == 1));
   end
endmodule

// File: rtl/i2c_ivec_regs.sv
module i2c_ivec_regs
   import i2c_ivec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned OFS_MASK = 0,
   parameter int unsigned OFS_STAT = 1,
   parameter int unsigned OFS_VEC  = 2,
   parameter bit          RD_CLR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [N_EVT-1:0]  flag_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [N_EVT-1:0]  sel_i,
   input  logic              rsf_i,
   input  logic              busy_i,
   output logic [N_EVT-1:0]  mask_o,
   output logic [N_EVT-1:0]  clr_o
);
   if (DATA_W < BUSY_BIT + 1) begin : g_bad_w
      $error("i2c_ivec_regs: DATA_W too narrow for status layout");
   end
   if (OFS_MASK == OFS_STAT || OFS_MASK == OFS_VEC || OFS_STAT == OFS_VEC) begin : g_bad_ofs
      $error("i2c_ivec_regs: register offsets must differ");
   end
   if (OFS_MASK >= 2**ADDR_W || OFS_STAT >= 2**ADDR_W || OFS_VEC >= 2**ADDR_W) begin : g_bad_a
      $error("i2c_ivec_regs: offset outside address space");
   end

   logic hit_mask, hit_stat, hit_vec;
   assign hit_mask = (addr_i == ADDR_W'(OFS_MASK));
   assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
   assign hit_vec  = (addr_i == ADDR_W'(OFS_VEC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mask_o <= '0;
      else if (wr_i && hit_mask) mask_o <= wdata_i[N_EVT-1:0];
   end

   logic [N_EVT-1:0] w1c_clr, rd_clr;
   assign w1c_clr = (wr_i && hit_stat) ? (wdata_i[N_EVT-1:0] & W1C_SET) : '0;

   if (RD_CLR_EN) begin : g_rdclr
      assign rd_clr = (rd_i && hit_vec) ? (sel_i & RDC_SET) : '0;
   end else begin : g_nordclr
      assign rd_clr = '0;
   end

   assign clr_o = w1c_clr | rd_clr;

   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[N_EVT-1:0] = flag_i;
      stat_word[RSF_BIT]   = rsf_i;
      stat_word[BUSY_BIT]  = busy_i;
   end

   always_comb begin
      rdata_o = '0;
      if (hit_mask)      rdata_o[N_EVT-1:0]  = mask_o;
      else if (hit_stat) rdata_o             = stat_word;
      else if (hit_vec)  rdata_o[CODE_W-1:0] = code_i;
   end
endmodule

// File: rtl/i2c_ivec_top.sv
module i2c_ivec_top
   import i2c_ivec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned OFS_MASK  = 0,
   parameter int unsigned OFS_STAT  = 1,
   parameter int unsigned OFS_VEC   = 2,
   parameter bit          RD_CLR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic              rx_shift_full,
   input  logic              bus_busy,
   output logic              irq
);
   logic [N_EVT-1:0]  flags, mask, clr, sel;
   logic [CODE_W-1:0] code;

   i2c_ivec_flags #(.N(N_EVT)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_pulse),
      .clr_i  (clr),
      .flag_o (flags)
   );

   i2c_ivec_prio #(.N(N_EVT)) u_prio (
      .req_i    (flags & mask),
      .code_o   (code),
      .onehot_o (sel)
   );

   i2c_ivec_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_MASK(OFS_MASK),
      .OFS_STAT(OFS_STAT), .OFS_VEC(OFS_VEC), .RD_CLR_EN(RD_CLR_EN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr),
      .wr_i    (reg_wr),
      .rd_i    (reg_rd),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .flag_i  (flags),
      .code_i  (code),
      .sel_i   (sel),
      .rsf_i   (rx_shift_full),
      .busy_i  (bus_busy),
      .mask_o  (mask),
      .clr_o   (clr)
   );

   assign irq = |(flags & mask);

   logic hit_stat, hit_vec;
   assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
   assign hit_vec  = (reg_addr == ADDR_W'(OFS_VEC));

   // R6: an interrupt always comes with a nonzero vector
   p_irq_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (code != '0));

   // R7: write-one to access-ready clears it when no new event arrives
   p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hit_stat && reg_wdata[2] && !evt_pulse[2]) |=> !flags[2]);

   // R8: status writes never clear arbitration-lost
   p_nonw1c_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hit_stat && flags[0]) |=> flags[0]);

   // R9: vector read keeps the access-ready flag
   p_rd_keeps_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && hit_vec && code == CODE_W'(VEC_ACCR)) |=> flags[2]);

   // R9: vector read clears reported arbitration-lost
   if (RD_CLR_EN) begin : g_rdclr_chk
      p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && hit_vec && code == CODE_W'(VEC_ARB) && !evt_pulse[0]) |=> !flags[0]);
   end
endmodule

// File: tb/i2c_ivec_top_tb_top.sv
module i2c_ivec_top_tb_top;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam logic [AW-1:0] A_MASK = 0, A_STAT = 1, A_VEC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [6:0]    evt_pulse = '0;
   logic          rx_shift_full = 1'b0, bus_busy = 1'b0;
   logic          irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2c_ivec_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse), .rx_shift_full(rx_shift_full),
      .bus_busy(bus_busy), .irq(irq)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // peek without side effects, sampled mid-cycle
   task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #2 d = reg_rdata;
   endtask

   // strobed read: side effects applied at the following edge
   task automatic rd_strobe(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #2 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk);
      evt_pulse = m;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic clear_all();
      logic [DW-1:0] d;
      wr(A_STAT, 16'h007F);
      wr(A_MASK, 16'h007F);
      for (int k = 0; k < 8; k++) rd_strobe(A_VEC, d);
      wr(A_MASK, 16'h0000);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      peek(A_MASK, d); chk("R1 mask", d, 16'h0);
      peek(A_STAT, d); chk("R1 status", d, 16'h0);
      peek(A_VEC, d);  chk("R1 vector", d, 16'h0);
      chk("R1 irq", {15'b0, irq}, 16'h0);
   endtask

   task automatic t_masked();
      logic [DW-1:0] d;
      pulse(7'h7F);
      peek(A_STAT, d); chk("R2 all set while masked", d, 16'h007F);
      peek(A_VEC, d);  chk("R5 vector zero while masked", d, 16'h0);
      chk("R6 irq low while masked", {15'b0, irq}, 16'h0);
      clear_all();
      peek(A_STAT, d); chk("R2 cleanup", d, 16'h0);
   endtask

   task automatic t_codes();
      logic [DW-1:0] d;
      for (int i = 0; i < 7; i++) begin
         wr(A_MASK, 16'h007F);
         pulse(7'(1 << i));
         peek(A_STAT, d); chk("R2 single bit", d, 16'(1 << i));
         peek(A_VEC, d);  chk("R3 code", d, 16'(i + 1));
         chk("R6 irq high", {15'b0, irq}, 16'h1);
         clear_all();
      end
   endtask

   task automatic t_prio();
      logic [DW-1:0] d;
      pulse(7'h7F);
      wr(A_MASK, 16'h007F); peek(A_VEC, d); chk("R4 all enabled", d, 16'd1);
      wr(A_MASK, 16'h007E); peek(A_VEC, d); chk("R4 no arb", d, 16'd2);
      wr(A_MASK, 16'h0068); peek(A_VEC, d); chk("R4 rx,stop,slave", d, 16'd4);
      wr(A_MASK, 16'h0040); peek(A_VEC, d); chk("R4 slave only", d, 16'd7);
      clear_all();
   endtask

   task automatic t_w1c();
      logic [DW-1:0] d;
      pulse(7'h7F);
      wr(A_STAT, 16'h0004); peek(A_STAT, d); chk("R7 clear bit2", d, 16'h007B);
      wr(A_STAT, 16'h0000); peek(A_STAT, d); chk("R7 zeros no effect", d, 16'h007B);
      wr(A_STAT, 16'h0053); peek(A_STAT, d); chk("R8 non-w1c ignored", d, 16'h007B);
      wr(A_STAT, 16'h0028); peek(A_STAT, d); chk("R7 clear bits3,5", d, 16'h0053);
   endtask

   task automatic t_rdclr();
      logic [DW-1:0] d;
      wr(A_MASK, 16'h007F);
      rd_strobe(A_VEC, d); chk("R9 code1", d, 16'd1);
      peek(A_STAT, d);     chk("R9 arb cleared", d, 16'h0052);
      rd_strobe(A_VEC, d); chk("R9 code2", d, 16'd2);
      rd_strobe(A_VEC, d); chk("R9 code5", d, 16'd5);
      rd_strobe(A_VEC, d); chk("R9 code7", d, 16'd7);
      peek(A_VEC, d);      chk("R9 drained", d, 16'd0);
      pulse(7'h2C);
      rd_strobe(A_VEC, d); chk("R9 code3", d, 16'd3);
      rd_strobe(A_VEC, d); chk("R9 code3 kept", d, 16'd3);
      peek(A_STAT, d);     chk("R9 w1c flags kept", d, 16'h002C);
      clear_all();
   endtask

   task automatic t_live();
      logic [DW-1:0] d;
      @(negedge clk); bus_busy = 1'b1; rx_shift_full = 1'b1;
      peek(A_STAT, d); chk("R10 live high", d, 16'h1800);
      wr(A_STAT, 16'h1800); peek(A_STAT, d); chk("R10 write ignored", d, 16'h1800);
      @(negedge clk); bus_busy = 1'b0;
      peek(A_STAT, d); chk("R10 busy low", d, 16'h0800);
      @(negedge clk); rx_shift_full = 1'b0;
      peek(A_STAT, d); chk("R10 both low", d, 16'h0000);
   endtask

   task automatic t_same_cycle();
      logic [DW-1:0] d;
      pulse(7'h04);
      @(negedge clk);
      reg_addr = A_STAT; reg_wdata = 16'h0004; reg_wr = 1'b1; evt_pulse = 7'h04;
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0;
      peek(A_STAT, d); chk("R11 set beats w1c", d, 16'h0004);
      wr(A_STAT, 16'h0004);
      pulse(7'h01);
      wr(A_MASK, 16'h0001);
      @(negedge clk);
      reg_addr = A_VEC; reg_rd = 1'b1; evt_pulse = 7'h01;
      @(negedge clk);
      reg_rd = 1'b0; evt_pulse = '0;
      peek(A_STAT, d); chk("R11 set beats read clear", d, 16'h0001);
      clear_all();
   endtask

   task automatic t_mask_rb();
      logic [DW-1:0] d;
      wr(A_MASK, 16'hFFFF); peek(A_MASK, d); chk("R12 mask width", d, 16'h007F);
      wr(A_MASK, 16'h0015); peek(A_MASK, d); chk("R12 mask value", d, 16'h0015);
      wr(A_MASK, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masked();
      t_codes();
      t_prio();
      t_w1c();
      clear_all();
      pulse(7'h53);
      t_rdclr();
      t_live();
      t_same_cycle();
      t_mask_rb();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule